// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the byte addresses for one DMA channel while it moves a block of memory. The source side and the destination side each have their own addressing mode. A linear side steps up or down by its access size. A planar side walks a rectangle row by row. A fixed side stays on one address, which suits a peripheral data register.

The rectangle geometry comes from two shared geometry slots, A and B. Each slot gives a row width, a row count and a row pitch. The channel chooses one slot with a select bit, and the block captures that slot's values when the transfer starts.

A controller pulses `start` with the configuration. After that it pulses `step` once for every element moved. The block raises `done` for one cycle when the transfer has finished.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, both addresses read 0 and `busy` and `done` are low.
- R2: A `start` pulse loads `src_start`/`dst_start` so that they appear on `src_addr`/`dst_addr` in the next cycle. `busy` then goes high, unless `count` is zero: in that case `busy` stays low and `done` never pulses.
- R3: The access-size codes are 2'b00 = 4 bytes, 2'b01 = 1 byte and 2'b10 = 2 bytes (2'b11 also counts as 4 bytes). On each accepted step, a linear side (mode 2'b00) moves its address by its own access size.
- R4: When `dec` is 1, linear sides decrement their address instead of incrementing it.
- R5: In mode 2'b10 and mode 2'b11, the address of that side stays at its start value for the whole transfer.
- R6: In mode 2'b01, the address advances by the access size within a row. Once the bytes moved in the current row reach the row width, the address jumps to the row start plus the row pitch. `dec` has no effect on a side in this mode.
- R7: `slot_sel` = 0 takes geometry from the A inputs and 1 takes it from the B inputs. The geometry is captured at `start`, so later changes to the slot inputs have no effect on a running transfer.
- R8: The moved byte count advances by the source access size. On the step that brings it to `count` or beyond, `done` goes high for exactly one cycle after that edge, and `busy` falls at the same edge.
- R9: A side in mode 2'b01 that completes its last row (row index y_size-1) ends the transfer with the same `done` pulse, even if `count` has not been reached.
- R10: A `step` pulse while idle is ignored. A `start` pulse in the same cycle as a `step` pulse takes priority, and no advance happens on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load configuration and begin a transfer |
| step | input | 1 | One element moved |
| src_start | input | 32 | Source start byte address |
| dst_start | input | 32 | Destination start byte address |
| src_mode | input | 2 | Source mode: 00 linear, 01 planar, 10/11 fixed |
| dst_mode | input | 2 | Destination mode, same encoding |
| src_size | input | 2 | Source access size code |
| dst_size | input | 2 | Destination access size code |
| dec | input | 1 | Linear sides count downward |
| slot_sel | input | 1 | Geometry slot select (0 = A, 1 = B) |
| count | input | 24 | Transfer byte count |
| a_xsize | input | 16 | Slot A row width in bytes |
| a_ysize | input | 16 | Slot A row count |
| a_wsize | input | 16 | Slot A row pitch in bytes |
| b_xsize | input | 16 | Slot B row width in bytes |
| b_ysize | input | 16 | Slot B row count |
| b_wsize | input | 16 | Slot B row pitch in bytes |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every result is registered. Addresses and `busy` change at the clock edge that samples `start` or `step`. `done` is high during the cycle that follows the final step edge. The bench updates a behavioural reference right after each rising edge, using the same input values that edge sampled, and compares all four outputs one time unit later. The planar reference computes each address directly from the side's total byte count as a quotient and a remainder of the row width. It keeps no running row pointer.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [1:0] {
    AM_LINEAR    = 2'b00,
    AM_PLANE     = 2'b01,
    AM_FIXED     = 2'b10,
    AM_FIXED_EOB = 2'b11
  } addr_mode_e;

  // Bytes per element for an access-size code.
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'b01:   size_bytes = 3'd1;
      2'b10:   size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  // Both fixed-address codes share bit 1.
  function automatic logic mode_is_fixed(input logic [1:0] mode);
    mode_is_fixed = mode[1];
  endfunction

endpackage

// File: rtl/dma2d_side.sv
module dma2d_side
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int GEO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [1:0]        mode_in,
  input  logic [1:0]        size_in,
  input  logic              dec_in,
  input  logic [GEO_W-1:0]  x_len,
  input  logic [GEO_W-1:0]  y_cnt,
  input  logic [GEO_W-1:0]  w_len,
  output logic [ADDR_W-1:0] addr,
  output logic              row_wrap,
  output logic              plane_end
);

  logic [ADDR_W-1:0] addr_q, base_q;
  logic [GEO_W:0]    inrow_q, inrow_nxt;
  logic [GEO_W-1:0]  row_q;
  logic [1:0]        mode_q, size_q;
  logic              dec_q;
  logic [2:0]        step_b;

  assign step_b    = size_bytes(size_q);
  assign inrow_nxt = inrow_q + {{(GEO_W-2){1'b0}}, step_b};
  assign row_wrap  = adv && (mode_q == AM_PLANE) && (inrow_nxt >= {1'b0, x_len});
  assign plane_end = row_wrap && (({1'b0, row_q} + 1'b1) >= {1'b0, y_cnt});
  assign addr      = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      base_q  <= '0;
      inrow_q <= '0;
      row_q   <= '0;
      mode_q  <= AM_LINEAR;
      size_q  <= 2'b00;
      dec_q   <= 1'b0;
    end else if (load) begin
      addr_q  <= start_addr;
      base_q  <= start_addr;
      inrow_q <= '0;
      row_q   <= '0;
      mode_q  <= mode_in;
      size_q  <= size_in;
      dec_q   <= dec_in;
    end else if (adv && !mode_is_fixed(mode_q)) begin
      if (mode_q == AM_PLANE) begin
        if (row_wrap) begin
          inrow_q <= '0;
          row_q   <= row_q + 1'b1;
          base_q  <= base_q + {{(ADDR_W-GEO_W){1'b0}}, w_len};
          addr_q  <= base_q + {{(ADDR_W-GEO_W){1'b0}}, w_len};
        end else begin
          inrow_q <= inrow_nxt;
          addr_q  <= addr_q + {{(ADDR_W-3){1'b0}}, step_b};
        end
      end else if (dec_q) begin
        addr_q <= addr_q - {{(ADDR_W-3){1'b0}}, step_b};
      end else begin
        addr_q <= addr_q + {{(ADDR_W-3){1'b0}}, step_b};
      end
    end
  end

  AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_is_fixed(mode_q) && !load) |=> $stable(addr_q)); // R5

  AST_LINEAR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode_q == AM_LINEAR && !dec_q) |=> (addr_q - $past(addr_q)) == ADDR_W'($past(step_b))); // R3

  AST_LINEAR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode_q == AM_LINEAR && dec_q) |=> ($past(addr_q) - addr_q) == ADDR_W'($past(step_b))); // R4

  AST_ROW_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    row_wrap |=> (addr_q - $past(base_q)) == ADDR_W'($past(w_len))); // R6

endmodule

// File: rtl/dma2d_track.sv
module dma2d_track
  import dma2d_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       src_size,
  input  logic             end_src,
  input  logic             end_dst,
  output logic             adv,
  output logic             busy,
  output logic             done
);

  logic [CNT_W:0]   moved_q, moved_nxt;
  logic [CNT_W-1:0] count_q;
  logic [1:0]       size_q;
  logic             busy_q, done_q, finish;

  assign adv       = step && busy_q && !load;
  assign moved_nxt = moved_q + {{(CNT_W-2){1'b0}}, size_bytes(size_q)};
  assign finish    = adv && ((moved_nxt >= {1'b0, count_q}) || end_src || end_dst);
  assign busy      = busy_q;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      moved_q <= '0;
      count_q <= '0;
      size_q  <= 2'b00;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (load) begin
        moved_q <= '0;
        count_q <= count;
        size_q  <= src_size;
        busy_q  <= (count != '0);
      end else if (adv) begin
        moved_q <= moved_nxt;
        if (finish) busy_q <= 1'b0;
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q); // R8

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (moved_q < {1'b0, count_q})); // R8

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int GEO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic [ADDR_W-1:0] src_start,
  input  logic [ADDR_W-1:0] dst_start,
  input  logic [1:0]        src_mode,
  input  logic [1:0]        dst_mode,
  input  logic [1:0]        src_size,
  input  logic [1:0]        dst_size,
  input  logic              dec,
  input  logic              slot_sel,
  input  logic [CNT_W-1:0]  count,
  input  logic [GEO_W-1:0]  a_xsize,
  input  logic [GEO_W-1:0]  a_ysize,
  input  logic [GEO_W-1:0]  a_wsize,
  input  logic [GEO_W-1:0]  b_xsize,
  input  logic [GEO_W-1:0]  b_ysize,
  input  logic [GEO_W-1:0]  b_wsize,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              busy,
  output logic              done
);

  logic [GEO_W-1:0] geo_x, geo_y, geo_w;
  logic             adv;
  logic             src_wrap, dst_wrap, src_end, dst_end;

  // Geometry captured from the selected slot at start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      geo_x <= '0;
      geo_y <= '0;
      geo_w <= '0;
    end else if (start) begin
      geo_x <= slot_sel ? b_xsize : a_xsize;
      geo_y <= slot_sel ? b_ysize : a_ysize;
      geo_w <= slot_sel ? b_wsize : a_wsize;
    end
  end

  dma2d_track #(.CNT_W(CNT_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .step     (step),
    .count    (count),
    .src_size (src_size),
    .end_src  (src_end),
    .end_dst  (dst_end),
    .adv      (adv),
    .busy     (busy),
    .done     (done)
  );

  dma2d_side #(.ADDR_W(ADDR_W), .GEO_W(GEO_W)) u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start),
    .adv        (adv),
    .start_addr (src_start),
    .mode_in    (src_mode),
    .size_in    (src_size),
    .dec_in     (dec),
    .x_len      (geo_x),
    .y_cnt      (geo_y),
    .w_len      (geo_w),
    .addr       (src_addr),
    .row_wrap   (src_wrap),
    .plane_end  (src_end)
  );

  dma2d_side #(.ADDR_W(ADDR_W), .GEO_W(GEO_W)) u_dst (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start),
    .adv        (adv),
    .start_addr (dst_start),
    .mode_in    (dst_mode),
    .size_in    (dst_size),
    .dec_in     (dec),
    .x_len      (geo_x),
    .y_cnt      (geo_y),
    .w_len      (geo_w),
    .addr       (dst_addr),
    .row_wrap   (dst_wrap),
    .plane_end  (dst_end)
  );

  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(src_addr) && $stable(dst_addr))); // R10

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (src_addr == $past(src_start) && dst_addr == $past(dst_start))); // R2

  AST_WRAP_NEEDS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (src_wrap || dst_wrap) |-> busy); // R6

endmodule

// File: tb/dma2d_addr_gen_bench.sv
module dma2d_addr_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, step = 1'b0;
  logic [31:0] src_start = '0, dst_start = '0;
  logic [1:0]  src_mode = '0, dst_mode = '0, src_size = '0, dst_size = '0;
  logic        dec = 1'b0, slot_sel = 1'b0;
  logic [23:0] count = '0;
  logic [15:0] a_xsize = '0, a_ysize = '0, a_wsize = '0;
  logic [15:0] b_xsize = '0, b_ysize = '0, b_wsize = '0;
  logic [31:0] src_addr, dst_addr;
  logic        busy, done;

  dma2d_addr_gen u_dma2d_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step),
    .src_start(src_start), .dst_start(dst_start),
    .src_mode(src_mode), .dst_mode(dst_mode),
    .src_size(src_size), .dst_size(dst_size),
    .dec(dec), .slot_sel(slot_sel), .count(count),
    .a_xsize(a_xsize), .a_ysize(a_ysize), .a_wsize(a_wsize),
    .b_xsize(b_xsize), .b_ysize(b_ysize), .b_wsize(b_wsize),
    .src_addr(src_addr), .dst_addr(dst_addr), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  // Reference state.
  longint m_sst = 0, m_dst = 0;
  int m_sb = 0, m_db = 0, m_smode = 0, m_dmode = 0, m_ssz = 0, m_dsz = 0, m_dec = 0;
  int gx = 0, gy = 0, gw = 0, m_cnt = 0;
  bit m_busy = 0, m_done = 0;

  function automatic int bsize(int c);
    return (c == 1) ? 1 : (c == 2) ? 2 : 4;
  endfunction

  function automatic longint side_addr(longint st, int mode, int b);
    longint r;
    if (mode >= 2)      r = st;
    else if (mode == 1) r = st + longint'((b / gx) * gw + (b % gx));
    else if (m_dec != 0) r = st - b;
    else                r = st + b;
    return r & 64'hFFFF_FFFF;
  endfunction

  function automatic bit plane_over(int mode, int b);
    return (mode == 1) && (gx > 0) && ((b / gx) >= gy);
  endfunction

  task automatic model_edge();
    bit fin = 0;
    if (start) begin
      m_sst = src_start; m_dst = dst_start;
      m_smode = src_mode; m_dmode = dst_mode;
      m_ssz = src_size; m_dsz = dst_size; m_dec = dec;
      m_cnt = count; m_sb = 0; m_db = 0;
      gx = slot_sel ? b_xsize : a_xsize;
      gy = slot_sel ? b_ysize : a_ysize;
      gw = slot_sel ? b_wsize : a_wsize;
      m_busy = (count != 0);
    end else if (step && m_busy) begin
      m_sb += bsize(m_ssz);
      m_db += bsize(m_dsz);
      fin = (m_sb >= m_cnt) || plane_over(m_smode, m_sb) || plane_over(m_dmode, m_db);
      if (fin) m_busy = 0;
    end
    m_done = fin;
  endtask

  task automatic cmp(string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_edge();
    #1;
    cmp("src_addr", longint'(src_addr), side_addr(m_sst, m_smode, m_sb));
    cmp("dst_addr", longint'(dst_addr), side_addr(m_dst, m_dmode, m_db));
    cmp("busy", longint'(busy), longint'(m_busy));
    cmp("done", longint'(done), longint'(m_done));
  endtask

  task automatic kick();
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic run(int n, int gap);
    for (int i = 0; i < n; i++) begin
      step = 1'b1; tick(); step = 1'b0;
      for (int g = 0; g < gap; g++) tick();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    cur_req = "R1";
    cmp("src_addr", longint'(src_addr), 0);
    cmp("busy", longint'(busy), 0);
    rst_n = 1'b1;
    tick(); tick();

    // R2 R3: linear up, 32-bit source, 8-bit destination
    cur_req = "R3";
    src_start = 32'h1000; dst_start = 32'h2000;
    src_mode = 2'b00; dst_mode = 2'b00; src_size = 2'b00; dst_size = 2'b01;
    count = 24'd16; dec = 1'b0;
    kick();
    run(4, 0); tick();

    // R3: 16-bit size code, gaps between steps
    src_size = 2'b10; dst_size = 2'b10; count = 24'd6;
    kick(); run(3, 2); tick();

    // R4 R5: decrement linear source, fixed destination
    cur_req = "R4";
    src_start = 32'h3000; dst_start = 32'h4000;
    src_size = 2'b10; dst_mode = 2'b10; dst_size = 2'b00; dec = 1'b1; count = 24'd8;
    kick(); run(4, 1); tick();

    // R5: end-of-burst fixed code on source
    cur_req = "R5";
    src_mode = 2'b11; dst_mode = 2'b00; dec = 1'b0; count = 24'd12;
    kick(); run(3, 0); tick();

    // R6 R7: planar source via slot A, 3 rows of 8 bytes, pitch 20
    cur_req = "R6";
    a_xsize = 16'd8; a_ysize = 16'd3; a_wsize = 16'd20;
    b_xsize = 16'd4; b_ysize = 16'd9; b_wsize = 16'd64;
    src_start = 32'h100; dst_start = 32'h800;
    src_mode = 2'b01; dst_mode = 2'b00; src_size = 2'b00; dst_size = 2'b00;
    slot_sel = 1'b0; count = 24'd24;
    kick(); run(6, 0); tick();

    // R7 R9: planar destination via slot B, dec ignored there; ends on rows
    cur_req = "R9";
    b_xsize = 16'd4; b_ysize = 16'd2; b_wsize = 16'd16;
    src_mode = 2'b00; dst_mode = 2'b01; src_size = 2'b01; dst_size = 2'b01;
    src_start = 32'h500; dst_start = 32'h900;
    dec = 1'b1; slot_sel = 1'b1; count = 24'd100;
    kick();
    cur_req = "R7";
    b_xsize = 16'd2; b_ysize = 16'd7; b_wsize = 16'd40;
    a_xsize = 16'd1; slot_sel = 1'b0;
    run(8, 0); tick(); tick();

    // R6: planar with 16-bit elements, slot A
    cur_req = "R6";
    a_xsize = 16'd6; a_ysize = 16'd2; a_wsize = 16'd10;
    src_mode = 2'b01; src_size = 2'b10; dst_mode = 2'b00; dst_size = 2'b10;
    dec = 1'b0; count = 24'd12; src_start = 32'h40; dst_start = 32'h80;
    kick(); run(6, 1); tick();

    // R2: zero count never goes busy
    cur_req = "R2";
    count = 24'd0; src_mode = 2'b00;
    kick(); run(3, 0);

    // R10: step while idle, start together with step
    cur_req = "R10";
    run(2, 1);
    count = 24'd8; src_start = 32'hFF0;
    step = 1'b1; start = 1'b1; tick(); start = 1'b0; step = 1'b0;
    tick();
    run(2, 0); tick();

    // R8: count reached on a step that overshoots
    cur_req = "R8";
    src_size = 2'b00; count = 24'd6;
    kick(); run(2, 0); tick(); tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule